// File: doc/BRIEF.md
# Floppy Drive Select and Control Registers

This block sits between a host I/O bus and a floppy disk controller. It holds two host-writable registers. The control register drives the spindle motor line and the head side line, and it holds an enable bit that gates the controller's interrupt request toward the host. The select register takes a mask with one bit per drive. The lowest set bit names the drive, and that drive's number is passed to the controller.

The drive number output, together with a one-cycle strobe, changes only when the chosen drive differs from the current one. Each drive has a media-changed flag that a media-inserted pulse sets. When the host switches to a drive, that drive's flag moves into a status bit and the flag is cleared. The host then reads the status bit and acknowledges it through a clear register at a third offset.

Top module: `fdsel_top`

## Requirements
- R1: After reset, motor_on, side_sel, irq_out, drv_stb and the status bit are 0, drv_num is 0, and all register reads return 0.
- R2: A write to offset 0x208 stores the byte. Bit 4 drives motor_on and bit 2 drives side_sel from the cycle after the write. A read of 0x208 returns the stored byte.
- R3: irq_out is fdc_irq_in ANDed with bit 0 of the control register. It follows fdc_irq_in in the same cycle.
- R4: A write to offset 0x20C stores the byte, which reads back from 0x20C. Of bits 3:0, the lowest set bit picks the drive (bit n picks drive n).
- R5: A select write with bits 3:0 all zero leaves drv_num unchanged.
- R6: drv_num takes the new value, and drv_stb is high for exactly the one cycle after the write edge, only when the picked drive differs from the current one. Otherwise drv_stb stays low.
- R7: On a drive change, the status bit (bit 0 of a read at 0x210) loads the new drive's media-changed flag, and that flag is cleared.
- R8: A media_ins[n] pulse sets drive n's flag. The flag is set even if, in the same cycle, a drive change clears it.
- R9: A write to 0x210 with bit 0 = 1 clears the status bit. With bit 0 = 0 the status bit is unchanged.
- R10: Writes to any other offset change nothing, and reads of any other offset, or with bus_rd low, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read enable |
| bus_addr | input | 16 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| fdc_irq_in | input | 1 | Interrupt request from the controller |
| media_ins | input | 4 | Per-drive media-inserted pulse |
| motor_on | output | 1 | Spindle motor line |
| side_sel | output | 1 | Head side line |
| drv_num | output | 2 | Drive number to the controller |
| drv_stb | output | 1 | Pulse marking a drive number update |
| irq_out | output | 1 | Gated interrupt to the host |

## Verification
The select register is exercised with masks that have one bit set and with masks that have several bits set, which tells lowest-bit priority apart from highest-bit priority. It also receives zero-low-nibble masks, which show that the drive is kept and not reset to 0. Repeated writes naming the current drive separate a strobe on change from a strobe on every write. A media pulse timed on the same edge as a switch to that drive shows whether the set or the clear wins. A reference model then replays pseudo-random bus traffic and media pulses, and its output is compared with the block's on every cycle.

// File: rtl/fdsel_pkg.sv
package fdsel_pkg;
  localparam int CTRL_IRQ_EN_BIT = 0;
  localparam int CTRL_SIDE_BIT   = 2;
  localparam int CTRL_MOTOR_BIT  = 4;
  localparam int STAT_CHG_BIT    = 0;

  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_CTRL = 2'd1,
    REG_DSEL = 2'd2,
    REG_STAT = 2'd3
  } fdsel_reg_e;
endpackage

// File: rtl/fdsel_decode.sv
module fdsel_decode
  import fdsel_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] ADDR_CTRL = 'h208,
  parameter logic [ADDR_W-1:0] ADDR_DSEL = 'h20C,
  parameter logic [ADDR_W-1:0] ADDR_STAT = 'h210
) (
  input  logic [ADDR_W-1:0] addr,
  output fdsel_reg_e        reg_sel
);
  always_comb begin
    if (addr == ADDR_CTRL)      reg_sel = REG_CTRL;
    else if (addr == ADDR_DSEL) reg_sel = REG_DSEL;
    else if (addr == ADDR_STAT) reg_sel = REG_STAT;
    else                        reg_sel = REG_NONE;
  end
endmodule

// File: rtl/fdsel_prio.sv
module fdsel_prio #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  mask,
  output logic          valid,
  output logic [IW-1:0] idx
);
  // descending scan so the lowest set bit is the last to assign
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i]) begin
        valid = 1'b1;
        idx   = IW'(i);
      end
    end
  end

  // R4: chosen index is a set bit with no lower set bit
  always_comb begin
    if (valid) begin
      assert_pick_lowest_R4: assert (mask[idx] && ((mask & ((N'(1) << idx) - N'(1))) == '0));
    end
  end
endmodule

// File: rtl/fdsel_media.sv
module fdsel_media #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  ins,
  input  logic          load,
  input  logic [IW-1:0] load_idx,
  input  logic          clr,
  output logic          status
);
  logic [N-1:0] flag_q, flag_d;
  logic         stat_q, stat_d;

  generate
    for (genvar d = 0; d < N; d++) begin : g_drv
      always_comb begin
        flag_d[d] = flag_q[d];
        if (load && (load_idx == IW'(d))) flag_d[d] = 1'b0;
        if (ins[d])                       flag_d[d] = 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q[d] <= 1'b0;
        else        flag_q[d] <= flag_d[d];
      end

      assert_ins_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ins[d] |=> flag_q[d]);
    end
  endgenerate

  always_comb begin
    stat_d = stat_q;
    if (load)     stat_d = flag_q[load_idx];
    else if (clr) stat_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= 1'b0;
    else        stat_q <= stat_d;
  end

  assign status = stat_q;

  assert_stat_rise_on_switch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q) |-> $past(load));
  assert_stat_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !load) |=> !stat_q);
endmodule

// File: rtl/fdsel_top.sv
module fdsel_top
  import fdsel_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int N_DRV  = 4,
  parameter logic [ADDR_W-1:0] ADDR_CTRL = 'h208,
  parameter logic [ADDR_W-1:0] ADDR_DSEL = 'h20C,
  parameter logic [ADDR_W-1:0] ADDR_STAT = 'h210,
  localparam int DRV_W = (N_DRV > 1) ? $clog2(N_DRV) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              fdc_irq_in,
  input  logic [N_DRV-1:0]  media_ins,
  output logic              motor_on,
  output logic              side_sel,
  output logic [DRV_W-1:0]  drv_num,
  output logic              drv_stb,
  output logic              irq_out
);
  fdsel_reg_e       reg_sel;
  logic [7:0]       ctrl_q, ctrl_d, dsel_q, dsel_d;
  logic [DRV_W-1:0] drv_q, drv_d;
  logic             stb_q, stb_d;
  logic             pick_valid, drv_change, stat_clr, status;
  logic [DRV_W-1:0] pick_idx;
  logic             wr_ctrl, wr_dsel, wr_stat;

  fdsel_decode #(
    .ADDR_W(ADDR_W), .ADDR_CTRL(ADDR_CTRL), .ADDR_DSEL(ADDR_DSEL), .ADDR_STAT(ADDR_STAT)
  ) i_decode (
    .addr(bus_addr), .reg_sel(reg_sel)
  );

  assign wr_ctrl = bus_wr && (reg_sel == REG_CTRL);
  assign wr_dsel = bus_wr && (reg_sel == REG_DSEL);
  assign wr_stat = bus_wr && (reg_sel == REG_STAT);

  fdsel_prio #(.N(N_DRV), .IW(DRV_W)) i_prio (
    .mask(bus_wdata[N_DRV-1:0]), .valid(pick_valid), .idx(pick_idx)
  );

  assign drv_change = wr_dsel && pick_valid && (pick_idx != drv_q);
  assign stat_clr   = wr_stat && bus_wdata[STAT_CHG_BIT];

  // next-state
  always_comb begin
    ctrl_d = ctrl_q;
    dsel_d = dsel_q;
    drv_d  = drv_q;
    stb_d  = 1'b0;
    if (wr_ctrl) ctrl_d = bus_wdata;
    if (wr_dsel) dsel_d = bus_wdata;
    if (drv_change) begin
      drv_d = pick_idx;
      stb_d = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      dsel_q <= '0;
      drv_q  <= '0;
      stb_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      dsel_q <= dsel_d;
      drv_q  <= drv_d;
      stb_q  <= stb_d;
    end
  end

  fdsel_media #(.N(N_DRV), .IW(DRV_W)) i_media (
    .clk(clk), .rst_n(rst_n), .ins(media_ins),
    .load(drv_change), .load_idx(pick_idx), .clr(stat_clr), .status(status)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (reg_sel)
        REG_CTRL: bus_rdata = ctrl_q;
        REG_DSEL: bus_rdata = dsel_q;
        REG_STAT: bus_rdata = {7'd0, status};
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign motor_on = ctrl_q[CTRL_MOTOR_BIT];
  assign side_sel = ctrl_q[CTRL_SIDE_BIT];
  assign drv_num  = drv_q;
  assign drv_stb  = stb_q;
  assign irq_out  = fdc_irq_in & ctrl_q[CTRL_IRQ_EN_BIT];

  assert_irq_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> fdc_irq_in);
  assert_stb_on_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drv_stb |-> (drv_num != $past(drv_num)));
  assert_change_has_stb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_num != $past(drv_num)) |-> drv_stb);
  assert_zero_mask_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dsel && bus_wdata[N_DRV-1:0] == '0) |=> $stable(drv_num));
endmodule

// File: tb/test_fdsel_top.sv
module test_fdsel_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        fdc_irq_in = 1'b0;
  logic [3:0]  media_ins = '0;
  logic        motor_on, side_sel, drv_stb, irq_out;
  logic [1:0]  drv_num;

  int total = 0, bad = 0;
  bit done = 0;

  // reference model state
  int m_ctrl = 0, m_sel = 0, m_drv = 0, m_stb = 0, m_stat = 0;
  int m_chg[4] = '{0, 0, 0, 0};

  always #10 clk = ~clk;

  fdsel_top i_fdsel_top (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fdc_irq_in(fdc_irq_in), .media_ins(media_ins), .motor_on(motor_on),
    .side_sel(side_sel), .drv_num(drv_num), .drv_stb(drv_stb), .irq_out(irq_out)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_sel = 0; m_drv = 0; m_stb = 0; m_stat = 0;
      for (int d = 0; d < 4; d++) m_chg[d] = 0;
    end else begin
      m_stb = 0;
      if (bus_wr) begin
        if (bus_addr == 16'h208) m_ctrl = bus_wdata;
        else if (bus_addr == 16'h20C) begin
          int pick;
          pick = -1;
          m_sel = bus_wdata;
          for (int b = 3; b >= 0; b--) if (bus_wdata[b]) pick = b;
          if (pick >= 0 && pick != m_drv) begin
            m_drv = pick; m_stb = 1; m_stat = m_chg[pick]; m_chg[pick] = 0;
          end
        end else if (bus_addr == 16'h210 && bus_wdata[0]) m_stat = 0;
      end
      for (int d = 0; d < 4; d++) if (media_ins[d]) m_chg[d] = 1;
    end
  end

  function automatic int m_rdata();
    if (!bus_rd) return 0;
    if (bus_addr == 16'h208) return m_ctrl;
    if (bus_addr == 16'h20C) return m_sel;
    if (bus_addr == 16'h210) return m_stat;
    return 0;
  endfunction

  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk("R2 motor_on", motor_on, (m_ctrl >> 4) & 1);
      chk("R2 side_sel", side_sel, (m_ctrl >> 2) & 1);
      chk("R3 irq_out", irq_out, fdc_irq_in & m_ctrl & 1);
      chk("R4 drv_num", drv_num, m_drv);
      chk("R6 drv_stb", drv_stb, m_stb);
      chk("R10 bus_rdata", bus_rdata, m_rdata());
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0; bus_addr = '0; #3;
  endtask

  task automatic rd(input logic [15:0] a, output int v);
    @(negedge clk); bus_rd = 1; bus_addr = a; #3; v = bus_rdata;
    @(negedge clk); bus_rd = 0; bus_addr = '0;
  endtask

  task automatic pulse_ins(input logic [3:0] m);
    @(negedge clk); media_ins = m;
    @(negedge clk); media_ins = '0;
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #3;
    chk("R1 motor", motor_on, 0); chk("R1 side", side_sel, 0);
    chk("R1 drv", drv_num, 0); chk("R1 stb", drv_stb, 0); chk("R1 irq", irq_out, 0);
    rd(16'h208, v); chk("R1 ctrl read", v, 0);
    rd(16'h210, v); chk("R1 stat read", v, 0);

    wr(16'h208, 8'h15);
    chk("R2 motor", motor_on, 1); chk("R2 side", side_sel, 1);
    rd(16'h208, v); chk("R2 readback", v, 8'h15);
    fdc_irq_in = 1; #1; chk("R3 irq enabled", irq_out, 1);
    wr(16'h208, 8'h10); chk("R3 irq masked", irq_out, 0);
    fdc_irq_in = 0;

    pulse_ins(4'b0100);
    wr(16'h20C, 8'h0C);
    chk("R4 lowest bit wins", drv_num, 2); chk("R6 strobe", drv_stb, 1);
    @(negedge clk); #3; chk("R6 one cycle", drv_stb, 0);
    rd(16'h210, v); chk("R7 status loaded", v, 1);
    wr(16'h210, 8'h00); rd(16'h210, v); chk("R9 bit0 zero keeps", v, 1);
    wr(16'h210, 8'h01); rd(16'h210, v); chk("R9 cleared", v, 0);
    wr(16'h20C, 8'h04); chk("R6 same drive no strobe", drv_stb, 0);
    rd(16'h210, v); chk("R7 no reload on same drive", v, 0);
    wr(16'h20C, 8'hF0); chk("R5 drive kept", drv_num, 2);
    rd(16'h20C, v); chk("R4 select readback", v, 8'hF0);
    wr(16'h20C, 8'h0F); chk("R4 all set picks 0", drv_num, 0);
    wr(16'h214, 8'hFF); chk("R10 stray write", motor_on, 1);
    rd(16'h214, v); chk("R10 stray read", v, 0);
    rd(16'h208, v); chk("R10 ctrl untouched", v, 8'h10);

    // media pulse on the same edge as a switch to that drive
    @(negedge clk); bus_wr = 1; bus_addr = 16'h20C; bus_wdata = 8'h02; media_ins = 4'b0010;
    @(negedge clk); bus_wr = 0; bus_addr = '0; media_ins = '0; #3;
    rd(16'h210, v); chk("R7 flag was clear", v, 0);
    wr(16'h20C, 8'h01); wr(16'h20C, 8'h02);
    rd(16'h210, v); chk("R8 set wins over clear", v, 1);

    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      bus_wr = ($urandom % 2) == 0;
      bus_rd = ($urandom % 2) == 0;
      case ($urandom % 4)
        0: bus_addr = 16'h208;
        1: bus_addr = 16'h20C;
        2: bus_addr = 16'h210;
        default: bus_addr = 16'h200 + 16'($urandom % 32);
      endcase
      bus_wdata = 8'($urandom);
      fdc_irq_in = ($urandom % 2) == 0;
      media_ins = (($urandom % 4) == 0) ? 4'($urandom) : 4'd0;
    end
    @(negedge clk); bus_wr = 0; bus_rd = 0; media_ins = '0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule